// File: doc/BRIEF.md
# Graphic LCD Segment Scan with Hardware Scroll

This block is the display-side scanner of a 64-column graphic LCD segment driver. Once per display line it selects one bit row out of a page-organised display RAM of 8 pages by 64 bytes, latches the 64 bits in a segment latch, and presents a per-segment drive code. That code tells the analog output stage whether each segment gets the select or the non-select level in the current alternation phase.

A line counter chooses which display line is scanned. While the frame pulse is high, the counter is loaded from a start-line input. A change to the start line therefore moves the whole picture vertically without rewriting the RAM. The column order can be mirrored so the same RAM image fits either panel orientation. The display-enable flag is sampled only at line boundaries, so the panel never switches on or off partway through a line.

The RAM is external. The block sends a page address and receives the full 512-bit page word combinationally in the same cycle. The line clock is modelled as a single-cycle line strobe in the system clock domain.

Top module: `lcd_seg_scan`

## Requirements
- R1: After reset the line counter is 0, the segment latch is all zeros and the display is off. Every seg_o bit then equals alt_i and ram_page_o is 0.
- R2: On every clock edge where frame_i is high, the line counter loads start_line_i. This applies even if a line strobe arrives in the same cycle. While frame_i is low, start_line_i has no effect.
- R3: When frame_i is low, each line strobe advances the line counter by one, and it wraps from 63 to 0. Without a strobe the counter holds its value.
- R4: For line L, ram_page_o equals L[5:3]. Column c of the page word is ram_row_i[8c+7:8c], and the bit taken from that column byte is bit L[2:0].
- R5: With col_fwd_i high, segment index k (seg_o[k]) is driven from column k.
- R6: With col_fwd_i low, seg_o[k] is driven from column 63-k.
- R7: The segment latch loads only on a line strobe, using the line value from before that strobe. Changes to RAM data or to col_fwd_i between strobes leave seg_o unchanged.
- R8: disp_on_i is sampled only on a line strobe. A change between strobes has no effect on seg_o.
- R9: While the sampled display state is off, every seg_o bit equals alt_i, whatever the latch and the RAM hold.
- R10: While the display is on, seg_o[k] = latch[k] XOR alt_i. A stored 1 selects (lights) the dot and a stored 0 gives the non-select level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | One-cycle line clock strobe |
| frame_i | input | 1 | Frame pulse, presets line counter while high |
| alt_i | input | 1 | LCD alternation phase |
| start_line_i | input | 6 | Display start line (scroll offset) |
| disp_on_i | input | 1 | Display enable, sampled on line strobe |
| col_fwd_i | input | 1 | 1: column 0 to segment 0; 0: mirrored |
| ram_page_o | output | 3 | Page address to display RAM |
| ram_row_i | input | 512 | Page word from RAM, 64 column bytes |
| seg_o | output | 64 | Per-segment drive code (select XOR alternation) |

## Verification
If the line counter is wrong, the next page address or latched bit row is wrong. A page error shows on ram_page_o in the same cycle. A bit-row error shows on seg_o one strobe later, so a miscount caused by a preset or a wrap is visible within one line. A latch or enable register that loads at the wrong time shows up only while the RAM, the column order or the enable flag is changed between strobes, so the stimulus deliberately changes them there. The alternation path is combinational, so an inversion error appears at once in every cycle.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_SEL_W = $clog2(BYTE_W);
endpackage

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
  parameter int unsigned LINES = 64,
  parameter int unsigned LW    = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_stb_i,
  input  logic          frame_i,
  input  logic [LW-1:0] start_i,
  output logic [LW-1:0] line_o
);
  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  logic [LW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         line_q <= '0;
    else if (frame_i)    line_q <= start_i;
    else if (line_stb_i) line_q <= (line_q == LAST) ? '0 : line_q + 1'b1;
  end

  assign line_o = line_q;

  p_preset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> line_q == $past(start_i));
  p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && line_stb_i) |=> int'(line_q) == (int'($past(line_q)) + 1) % int'(LINES));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !line_stb_i) |=> $stable(line_q));
endmodule

// File: rtl/lcd_row_select.sv
module lcd_row_select
  import lcd_scan_pkg::*;
#(
  parameter int unsigned COLS = 64
) (
  input  logic [BIT_SEL_W-1:0]   bit_sel_i,
  input  logic                   col_fwd_i,
  input  logic [COLS*BYTE_W-1:0] row_i,
  output logic [COLS-1:0]        bits_o
);
  logic [COLS-1:0] col_bits;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [BYTE_W-1:0] col_byte;
    assign col_byte    = row_i[c*BYTE_W +: BYTE_W];
    assign col_bits[c] = col_byte[bit_sel_i];
  end

  // mirrored order maps segment k to column COLS-1-k
  for (genvar k = 0; k < COLS; k++) begin : g_seg
    assign bits_o[k] = col_fwd_i ? col_bits[k] : col_bits[COLS-1-k];
  end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive #(
  parameter int unsigned COLS = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_stb_i,
  input  logic            disp_on_i,
  input  logic            alt_i,
  input  logic [COLS-1:0] bits_i,
  output logic [COLS-1:0] seg_o
);
  logic [COLS-1:0] lat_q;
  logic            on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      on_q  <= 1'b0;
    end else if (line_stb_i) begin
      lat_q <= bits_i;
      on_q  <= disp_on_i;
    end
  end

  // off forces non-select: code equals alternation phase
  assign seg_o = (lat_q & {COLS{on_q}}) ^ {COLS{alt_i}};

  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_i |=> $stable(lat_q));
  p_latch_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stb_i |=> lat_q == $past(bits_i));
  p_on_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_i |=> $stable(on_q));
endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan
  import lcd_scan_pkg::*;
#(
  parameter int unsigned COLS  = 64,
  parameter int unsigned LINES = 64,
  parameter int unsigned LW    = $clog2(LINES),
  parameter int unsigned PW    = $clog2(LINES / BYTE_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   line_stb_i,
  input  logic                   frame_i,
  input  logic                   alt_i,
  input  logic [LW-1:0]          start_line_i,
  input  logic                   disp_on_i,
  input  logic                   col_fwd_i,
  output logic [PW-1:0]          ram_page_o,
  input  logic [COLS*BYTE_W-1:0] ram_row_i,
  output logic [COLS-1:0]        seg_o
);
  logic [LW-1:0]   line;
  logic [COLS-1:0] row_bits;

  lcd_line_ctr #(.LINES(LINES), .LW(LW)) u_line_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_stb_i (line_stb_i),
    .frame_i    (frame_i),
    .start_i    (start_line_i),
    .line_o     (line)
  );

  assign ram_page_o = line[LW-1:BIT_SEL_W];

  lcd_row_select #(.COLS(COLS)) u_row_select (
    .bit_sel_i (line[BIT_SEL_W-1:0]),
    .col_fwd_i (col_fwd_i),
    .row_i     (ram_row_i),
    .bits_o    (row_bits)
  );

  lcd_seg_drive #(.COLS(COLS)) u_seg_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_stb_i (line_stb_i),
    .disp_on_i  (disp_on_i),
    .alt_i      (alt_i),
    .bits_i     (row_bits),
    .seg_o      (seg_o)
  );

  p_page_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !line_stb_i) |=> $stable(ram_page_o));
endmodule

// File: tb/lcd_seg_scan_bench.sv
`timescale 1ns/1ps
module lcd_seg_scan_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stb = 1'b0, frame = 1'b0, alt = 1'b0, don = 1'b0, fwd = 1'b1;
  logic [5:0]   start = '0;
  logic [2:0]   page;
  logic [511:0] row;
  logic [63:0]  seg;
  logic [7:0]   seed = 8'h00;

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  int       m_z = 0;
  bit       m_on = 0;
  bit [63:0] m_lat = '0;

  always #2 clk = ~clk;

  lcd_seg_scan u_lcd_seg_scan (
    .clk_i(clk), .rst_ni(rst_n), .line_stb_i(stb), .frame_i(frame), .alt_i(alt),
    .start_line_i(start), .disp_on_i(don), .col_fwd_i(fwd),
    .ram_page_o(page), .ram_row_i(row), .seg_o(seg)
  );

  function automatic logic [7:0] ram_byte(int p, int c);
    return 8'((p * 37 + c * 11 + 5) % 256) ^ seed;
  endfunction

  always_comb begin
    for (int c = 0; c < 64; c++) row[c*8 +: 8] = ram_byte(int'(page), c);
  end

  function automatic bit [63:0] exp_seg();
    bit [63:0] e;
    for (int k = 0; k < 64; k++) e[k] = (m_on & m_lat[k]) ^ alt;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_z = 0; m_on = 0; m_lat = '0;
    end else begin
      if (stb) begin
        for (int k = 0; k < 64; k++) begin
          int col;
          logic [7:0] b;
          col = fwd ? k : 63 - k;
          b = ram_byte(m_z / 8, col);
          m_lat[k] = b[m_z % 8];
        end
        m_on = don;
      end
      if (frame) m_z = int'(start);
      else if (stb) m_z = (m_z + 1) % 64;
    end
    #1;
    checks++;
    if (seg !== exp_seg()) begin
      fails++;
      $display("FAIL %s seg actual=%h expected=%h", cur_req, seg, exp_seg());
    end
    checks++;
    if (int'(page) != m_z / 8) begin
      fails++;
      $display("FAIL %s/R4 page actual=%0d expected=%0d", cur_req, page, m_z / 8);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_pulse();
    stb = 1'b1; @(negedge clk); stb = 1'b0; idle(2);
  endtask

  task automatic frame_start(logic [5:0] s);
    start = s; frame = 1'b1; idle(2); frame = 1'b0; idle(1);
  endtask

  initial begin
    idle(3);
    cur_req = "R1";
    checks++;
    if (seg !== {64{alt}} || page !== 3'd0) begin
      fails++;
      $display("FAIL R1 reset seg=%h page=%0d expected=%h page 0", seg, page, {64{alt}});
    end
    rst_n = 1'b1; idle(2);

    // R3 R4 R5: forward scan across wrap
    cur_req = "R5";
    don = 1'b1; fwd = 1'b1;
    frame_start(6'd0);
    line_pulse();
    cur_req = "R3";
    for (int i = 0; i < 70; i++) line_pulse();

    // R2 R6: scrolled, mirrored
    cur_req = "R6";
    fwd = 1'b0;
    frame_start(6'd37);
    for (int i = 0; i < 30; i++) line_pulse();

    // R2: start change without frame, then frame with coincident strobe
    cur_req = "R2";
    start = 6'd5; idle(3); line_pulse();
    start = 6'd62; frame = 1'b1; stb = 1'b1; @(negedge clk); stb = 1'b0; frame = 1'b0; idle(2);
    for (int i = 0; i < 4; i++) line_pulse();

    // R7: RAM and order changes between strobes
    cur_req = "R7";
    seed = 8'hA5; idle(4);
    fwd = 1'b1; idle(4);
    line_pulse();

    // R10: alternation
    cur_req = "R10";
    for (int i = 0; i < 10; i++) begin alt = ~alt; line_pulse(); idle(1); alt = ~alt; idle(1); end

    // R8 R9: enable sampled at strobe, off forces non-select
    cur_req = "R8";
    don = 1'b0; idle(5); alt = 1'b1; idle(2);
    cur_req = "R9";
    line_pulse();
    for (int i = 0; i < 6; i++) begin alt = ~alt; line_pulse(); end
    cur_req = "R8";
    don = 1'b1; idle(3); line_pulse(); line_pulse();

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule